// File: doc/BRIEF.md
# Binary Extension Field Multiply-Accumulate Unit

This block multiplies two elements of a binary extension field GF(2^m) and can fold a third operand into the product by XOR, which is how field addition works. The field is chosen by a polynomial register of XLEN bits. When that register is written, the field degree, the reduction term and an element mask are derived once and cached. Later operations reuse those cached values and never decode the register again.

An operation starts with a one-cycle `start` while the unit is idle. The operands are latched and masked to the field width. The unit then runs a shift-and-add loop that handles one multiplier bit per clock. After each step the multiplicand is doubled and reduced. Once as many steps as the field degree have run, `done` pulses for one cycle. `result` holds the value until the next completion.

The polynomial register uses a compact encoding:
- A value of 0 or 2 selects the field GF(2) with polynomial x.
- Any other value with a clear LSB stands for a polynomial of full XLEN degree. The LSB is implied to be one.
- Any other odd value gives its own degree, which is the position of its highest set bit.

Top module: `gf2m_mac`

## Requirements
- R1: After reset `busy`, `done` and `result` are all zero. The polynomial register decodes as if the value 0 had been written, so the field is GF(2) and 1·1 gives 1.
- R2: A written polynomial of 0 or 2 selects degree 1 with polynomial x. An odd value selects degree floor(log2(value)) with the value itself as the polynomial. The value 1 gives degree 0, and every result in that field is 0.
- R3: A written polynomial with bit 0 clear, other than 0 or 2, selects degree XLEN with polynomial x^XLEN + (value OR 1). For example, with 0x1A, (x^63)·x gives 0x1B.
- R4: With `acc_en` low, `result` is A·B reduced by the active polynomial. Two reference cases: 0x07·0x05 gives 0x06 under 0b1011, and 0x80·0x83 gives 0x01 under 0x11B.
- R5: With `acc_en` high, `result` is the field product XOR C.
- R6: `done` is high for exactly one cycle, max(degree,1) rising edges after the edge that accepted `start`. `busy` is high from the accepting edge until `done` rises. `result` changes only together with `done`.
- R7: A `start` while `busy` is high is ignored. It does not alter the running result or its latency, and it produces no extra `done`.
- R8: A polynomial write while `busy` is high is ignored. A `start` in the same cycle as an accepted write is dropped, and the write takes effect from the next cycle.
- R9: Bits of A, B and C at or above the field degree are cleared on input and have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_we | input | 1 | Write strobe for the field polynomial register |
| poly_wdata | input | XLEN | Encoded field polynomial |
| start | input | 1 | Begin an operation when idle |
| acc_en | input | 1 | 1: multiply then XOR C; 0: multiply only |
| op_a | input | XLEN | Multiplicand A |
| op_b | input | XLEN | Multiplier B |
| op_c | input | XLEN | Addend C |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Last completed result, held between completions |

## Verification
`done` is due exactly max(degree,1) rising edges after the edge that samples `start`: 1 edge for GF(2), 3 for 0b1011, 8 for the 8-bit field and XLEN for a full-width polynomial. The bench drives inputs on falling edges and counts falling edges after the accepting edge until `done` appears. It compares that count with the degree it decodes on its own side, and compares the result in the same half-cycle. One falling edge later it checks that `done` has dropped and `result` is unchanged. After a start or a polynomial write has been injected into a running operation, the bench watches twelve further cycles for any stray `busy` or `done`.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/gf2m_field_reg.sv
module gf2m_field_reg #(
    parameter int XLEN = 64,
    parameter int DW   = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [DW-1:0]   deg_o,
    output logic [XLEN-1:0] red_o,
    output logic [XLEN-1:0] mask_o
);

    typedef struct packed {
        logic [DW-1:0]   deg;
        logic [XLEN-1:0] red;
        logic [XLEN-1:0] mask;
    } field_t;

    field_t fld_d, fld_q;

    always_comb begin
        logic [DW-1:0] top_bit;
        fld_d   = fld_q;
        top_bit = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (wr_data[i]) top_bit = DW'(i);
        end
        if (wr_en) begin
            if (wr_data == XLEN'(0) || wr_data == XLEN'(2)) begin
                fld_d.deg = DW'(1);
                fld_d.red = '0;
            end else if (!wr_data[0]) begin
                fld_d.deg = DW'(XLEN);
                fld_d.red = wr_data | XLEN'(1);
            end else begin
                fld_d.deg = top_bit;
                fld_d.red = wr_data ^ (XLEN'(1) << top_bit);
            end
            for (int i = 0; i < XLEN; i++) begin
                fld_d.mask[i] = (DW'(i) < fld_d.deg);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q.deg  <= DW'(1);
            fld_q.red  <= '0;
            fld_q.mask <= XLEN'(1);
        end else begin
            fld_q <= fld_d;
        end
    end

    assign deg_o  = fld_q.deg;
    assign red_o  = fld_q.red;
    assign mask_o = fld_q.mask;

endmodule

// File: rtl/gf2m_step.sv
module gf2m_step #(
    parameter int XLEN = 64,
    parameter int DW   = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic            b_bit_i,
    input  logic [XLEN-1:0] p_i,
    input  logic [DW-1:0]   deg_i,
    input  logic [XLEN-1:0] red_i,
    input  logic [XLEN-1:0] mask_i,
    output logic [XLEN-1:0] a_o,
    output logic [XLEN-1:0] p_o
);

    logic [XLEN:0] a_dbl;

    always_comb begin
        p_o   = b_bit_i ? (p_i ^ a_i) : p_i;
        a_dbl = {a_i, 1'b0};
        if (a_dbl[deg_i]) begin
            a_o = (a_dbl[XLEN-1:0] ^ red_i) & mask_i;
        end else begin
            a_o = a_dbl[XLEN-1:0] & mask_i;
        end
    end

endmodule

// File: rtl/gf2m_mac.sv
module gf2m_mac
    import gf2m_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            poly_we,
    input  logic [XLEN-1:0] poly_wdata,
    input  logic            start,
    input  logic            acc_en,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_c,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);

    localparam int DW = $clog2(XLEN + 1);

    typedef struct packed {
        phase_e          ph;
        logic [DW-1:0]   cnt;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] p;
        logic [XLEN-1:0] c;
        logic            macc;
        logic            done;
        logic [XLEN-1:0] result;
    } state_t;

    state_t s_d, s_q;

    logic [DW-1:0]   poly_deg;
    logic [XLEN-1:0] poly_red;
    logic [XLEN-1:0] poly_mask;
    logic [XLEN-1:0] step_a;
    logic [XLEN-1:0] step_p;
    logic            wr_take;

    assign wr_take = poly_we && (s_q.ph == PH_IDLE);

    gf2m_field_reg #(.XLEN(XLEN), .DW(DW)) u_field (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_take),
        .wr_data (poly_wdata),
        .deg_o   (poly_deg),
        .red_o   (poly_red),
        .mask_o  (poly_mask)
    );

    gf2m_step #(.XLEN(XLEN), .DW(DW)) u_step (
        .a_i     (s_q.a),
        .b_bit_i (s_q.b[0]),
        .p_i     (s_q.p),
        .deg_i   (poly_deg),
        .red_i   (poly_red),
        .mask_i  (poly_mask),
        .a_o     (step_a),
        .p_o     (step_p)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (start && !poly_we) begin
                    s_d.ph   = PH_RUN;
                    s_d.a    = op_a & poly_mask;
                    s_d.b    = op_b & poly_mask;
                    s_d.c    = op_c & poly_mask;
                    s_d.p    = '0;
                    s_d.macc = acc_en;
                    s_d.cnt  = (poly_deg == '0) ? DW'(1) : poly_deg;
                end
            end
            PH_RUN: begin
                s_d.a   = step_a;
                s_d.p   = step_p;
                s_d.b   = s_q.b >> 1;
                s_d.cnt = s_q.cnt - DW'(1);
                if (s_q.cnt == DW'(1)) begin
                    s_d.ph     = PH_IDLE;
                    s_d.done   = 1'b1;
                    s_d.result = s_q.macc ? (step_p ^ s_q.c) : step_p;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph     <= PH_IDLE;
            s_q.cnt    <= '0;
            s_q.a      <= '0;
            s_q.b      <= '0;
            s_q.p      <= '0;
            s_q.c      <= '0;
            s_q.macc   <= 1'b0;
            s_q.done   <= 1'b0;
            s_q.result <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.ph == PH_RUN);
    assign done   = s_q.done;
    assign result = s_q.result;

endmodule

// File: rtl/gf2m_mac_chk.sv
module gf2m_mac_chk #(
    parameter int XLEN = 64,
    parameter int DW   = $clog2(XLEN + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            poly_we,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic [DW-1:0]   deg
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R6

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !poly_we) |=> busy) else $error("start not taken"); // R6

    AST_WRITE_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && poly_we) |=> !busy) else $error("start taken with write"); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)) else $error("result moved without done"); // R6

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done) else $error("busy dropped without done"); // R7

    AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(deg)) else $error("field changed during run"); // R8

    AST_DEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        deg <= DW'(XLEN)) else $error("degree out of range"); // R2

endmodule

bind gf2m_mac gf2m_mac_chk #(.XLEN(XLEN), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .poly_we (poly_we),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .deg     (poly_deg)
);

// File: tb/gf2m_mac_bench.sv
module gf2m_mac_bench;

    localparam int XLEN       = 64;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            poly_we = 1'b0;
    logic [XLEN-1:0] poly_wdata = '0;
    logic            start = 1'b0;
    logic            acc_en = 1'b0;
    logic [XLEN-1:0] op_a = '0;
    logic [XLEN-1:0] op_b = '0;
    logic [XLEN-1:0] op_c = '0;
    logic            busy;
    logic            done;
    logic [XLEN-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    logic [XLEN-1:0] cur_poly = '0;

    gf2m_mac #(.XLEN(XLEN)) u_gf2m_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .poly_we    (poly_we),
        .poly_wdata (poly_wdata),
        .start      (start),
        .acc_en     (acc_en),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_c       (op_c),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int ref_deg(input logic [XLEN-1:0] v);
        int d;
        if (v == 0 || v == 2) return 1;
        if (!v[0]) return XLEN;
        d = 0;
        for (int i = 0; i < XLEN; i++) if (v[i]) d = i;
        return d;
    endfunction

    function automatic logic [XLEN-1:0] ref_mask(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] m;
        int d;
        d = ref_deg(v);
        for (int i = 0; i < XLEN; i++) m[i] = (i < d);
        return m;
    endfunction

    function automatic logic [XLEN-1:0] ref_mul(input logic [XLEN-1:0] v,
                                                input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
        logic [XLEN:0]   full, aa;
        logic [XLEN-1:0] bb, p, m;
        int d;
        d = ref_deg(v);
        m = ref_mask(v);
        if (v == 0 || v == 2) full = (XLEN+1)'(2);
        else if (!v[0])       full = {1'b1, v | XLEN'(1)};
        else                  full = {1'b0, v};
        aa = {1'b0, a & m};
        bb = b & m;
        p  = '0;
        for (int i = 0; i < d; i++) begin
            if (bb[i]) p = p ^ aa[XLEN-1:0];
            aa = aa << 1;
            if (aa[d]) aa = aa ^ full;
        end
        return p;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_poly(input logic [XLEN-1:0] v);
        @(negedge clk);
        poly_we    = 1'b1;
        poly_wdata = v;
        @(negedge clk);
        poly_we    = 1'b0;
        cur_poly   = v;
    endtask

    // mode 0: plain; 1: start injected while busy (R7); 2: write injected while busy (R8)
    task automatic run_op(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                          input logic [XLEN-1:0] c, input logic macc,
                          input int mode, input string req);
        logic [XLEN-1:0] exp;
        int lat, exp_lat, stray;
        exp = ref_mul(cur_poly, a, b);
        if (macc) exp = exp ^ (c & ref_mask(cur_poly));
        exp_lat = (ref_deg(cur_poly) == 0) ? 1 : ref_deg(cur_poly);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; op_c = c; acc_en = macc;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0; op_c = '0; acc_en = 1'b0;
        lat = 0;
        while (!done && lat < XLEN + 4) begin
            if (mode == 1 && lat == 1) begin
                start = 1'b1; op_a = ~a; op_b = ~b; op_c = ~c; acc_en = ~macc;
            end else if (mode == 2 && lat == 1) begin
                poly_we = 1'b1; poly_wdata = XLEN'(64'hB);
            end else begin
                start = 1'b0; poly_we = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0; poly_we = 1'b0;
        check(done, "R6 done pulse", XLEN'(done), XLEN'(1));
        check(result == exp, req, result, exp);
        check(lat == exp_lat, "R6 latency", XLEN'(lat), XLEN'(exp_lat));
        @(negedge clk);
        check(!done && result == exp, "R6 pulse width / hold", result, exp);
        if (mode != 0) begin
            stray = 0;
            repeat (12) begin
                @(negedge clk);
                if (done || busy) stray++;
            end
            check(stray == 0, (mode == 1) ? "R7 no extra run" : "R8 no extra run",
                  XLEN'(stray), XLEN'(0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] polys [5];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && result == '0, "R1 reset outputs", result, '0);

        // R1: reset field is GF(2); R9: bits above degree ignored
        run_op(1, 1, 0, 0, 0, "R1 reset field 1*1");
        run_op(3, 3, 2, 1, 0, "R9 GF(2) masked operands");

        // R2: decoding edge values
        write_poly(XLEN'(3));
        run_op(1, 1, 0, 0, 0, "R2 poly x+1");
        write_poly(XLEN'(1));
        run_op(1, 1, 1, 1, 0, "R2 degree zero gives zero");
        check(result == '0, "R2 degree zero literal", result, '0);
        write_poly(XLEN'(2));
        run_op(1, 1, 0, 0, 0, "R2 value 2 is GF(2)");

        // R4: reference vectors
        write_poly(XLEN'(64'hB));
        run_op(7, 5, 0, 0, 0, "R4 0b1011 field");
        check(result == XLEN'(6), "R4 literal 0x06", result, XLEN'(6));
        write_poly(XLEN'(64'h11B));
        run_op(64'h80, 64'h83, 0, 0, 0, "R4 AES field");
        check(result == XLEN'(1), "R4 literal 0x01", result, XLEN'(1));

        // R5 and R9
        run_op(64'h80, 64'h83, 64'h55, 1, 0, "R5 multiply-add");
        check(result == XLEN'(64'h54), "R5 literal 0x54", result, XLEN'(64'h54));
        run_op(64'h180, 64'hF83, 64'h155, 1, 0, "R9 high bits masked");
        check(result == XLEN'(64'h54), "R9 literal 0x54", result, XLEN'(64'h54));

        // R7 / R8 injections
        run_op(64'h80, 64'h83, 0, 0, 1, "R7 start while busy");
        run_op(64'h80, 64'h83, 0, 0, 2, "R8 write while busy");
        run_op(64'h80, 64'h83, 0, 0, 0, "R8 field kept after ignored write");

        // R8: start with accepted write is dropped
        @(negedge clk);
        start = 1'b1; poly_we = 1'b1; poly_wdata = XLEN'(64'hB);
        op_a = 7; op_b = 5;
        @(negedge clk);
        start = 1'b0; poly_we = 1'b0;
        cur_poly = XLEN'(64'hB);
        begin
            int stray = 0;
            repeat (12) begin
                @(negedge clk);
                if (done || busy) stray++;
            end
            check(stray == 0, "R8 start dropped with write", XLEN'(stray), '0);
        end
        run_op(7, 5, 0, 0, 0, "R8 write took effect");

        // R3: full-degree field
        write_poly(XLEN'(64'h1A));
        run_op(XLEN'(1) << (XLEN - 1), 2, 0, 0, 0, "R3 full degree wrap");
        check(result == XLEN'(64'h1B), "R3 literal 0x1B", result, XLEN'(64'h1B));

        // random mix
        polys[0] = XLEN'(64'h11B);
        polys[1] = XLEN'(64'hB);
        polys[2] = {$urandom(), $urandom()} & ~XLEN'(1);
        polys[3] = {1'b0, 31'($urandom()), $urandom()} | XLEN'(1);
        polys[4] = XLEN'(64'h1A);
        for (int k = 0; k < 5; k++) begin
            write_poly(polys[k]);
            for (int n = 0; n < 15; n++) begin
                run_op({$urandom(), $urandom()}, {$urandom(), $urandom()},
                       {$urandom(), $urandom()}, 1'($urandom()), 0,
                       (k == 2 || k == 4) ? "R3 random" : "R4/R5 random");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule